// File: doc/BRIEF.md
# I2S Receiver to Ordered Audio Stream Packer

This block receives serial audio on a shared bit clock and word select, with one serial data line for each stereo pair (up to four pairs, so eight channels). It turns every received sample into one 32-bit stream word. Each word carries the sample in a fixed field, a 4-bit marker in the lowest nibble, and a channel number on a separate 3-bit ID. Once both halves of a frame have arrived, all channels of that frame are sent in ascending channel order, and the sender waits on the ready signal of the receiver.

The serial inputs are asynchronous to the streaming clock. They are synchronised, and the rising edges of the bit clock are detected in the streaming domain, so the streaming clock must be several times faster than the bit clock. A counter of sent frames marks the first channel-0 word of every 192-frame audio block with its own marker. If a new frame completes while the previous one is still being sent, the new frame is dropped and a sticky overflow flag goes high. The sample width is set at build time to 16 or 24 bits. The pair count is 1, 2 or 4.

Top module: `i2s_stream_packer`

## Requirements
- R1: Reset is synchronous and active-low. While reset is held and after it is released, `m_axis_tvalid` and `overflow` are 0 until a complete frame has been received.
- R2: A word is transferred only in a cycle where `m_axis_tvalid` and `m_axis_tready` are both 1. While `m_axis_tvalid` is 1 and `m_axis_tready` is 0, the data and ID hold steady. Within a frame, IDs run 0, 1, ..., 2*NUM_PAIRS-1 in that order.
- R3: `m_axis_tdata[3:0]` is 4'b0001 on the channel-0 word that opens an audio block, 4'b0010 on every other even-ID (left) word and 4'b0011 on every odd-ID (right) word.
- R4: An audio block is 192 sent frames. Sent frames 0, 192, 384, ... carry the block-opening marker on channel 0.
- R5: `m_axis_tdata[31:28]` is always 0.
- R6: With SAMPLE_W = 24, the sample occupies `m_axis_tdata[27:4]`, with its MSB at bit 27.
- R7: With SAMPLE_W = 16, the sample occupies `m_axis_tdata[27:12]` and `m_axis_tdata[11:4]` is 0.
- R8: Serial data is sampled on rising bit-clock edges. A word's MSB is the bit sampled one bit clock after a word-select change. Word select 0 means left. The left sample of line p is sent with ID 2p and the right sample with ID 2p+1.
- R9: If a frame completes while any word of the previous frame is still unaccepted, the new frame is dropped whole, `overflow` goes to 1 and stays 1 until reset, and the block counter does not advance for the dropped frame.
- R10: A right sample with no left sample received before it since the last frame (for example, the first right half after reset) produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streaming clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i2s_bclk | input | 1 | Serial bit clock (asynchronous) |
| i2s_ws | input | 1 | Word select, 0 = left |
| i2s_sd | input | NUM_PAIRS | Serial data, one line per stereo pair |
| m_axis_tdata | output | 32 | Packed word: marker [3:0], sample [27:4], zero [31:28] |
| m_axis_tid | output | 3 | Channel number |
| m_axis_tvalid | output | 1 | Word valid |
| m_axis_tready | input | 1 | Receiver ready |
| overflow | output | 1 | Sticky flag: a frame was dropped |

## Verification
The assertions assume that the bit clock stays high and low for at least three streaming cycles each, that word select and data change only while the bit clock is low, and that each half-frame lasts at least SAMPLE_W+1 bit clocks. The sequencing and marker checks rely on these conditions. The bench uses a bit clock of eight streaming cycles, changes word select and data at the start of the low phase, and uses 32-bit half-frames. The ready signal is free to stall at any time. The bench holds it low for more than a full frame once to force a drop.

// File: rtl/i2s_stream_pkg.sv
package i2s_stream_pkg;
  localparam int TDATA_W   = 32;
  localparam int TID_W     = 3;
  localparam int FIELD_W   = 24;
  localparam logic [3:0] MARK_BLOCK = 4'b0001;
  localparam logic [3:0] MARK_LEFT  = 4'b0010;
  localparam logic [3:0] MARK_RIGHT = 4'b0011;
endpackage

// File: rtl/i2s_edge_sync.sv
module i2s_edge_sync #(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_in,
  input  logic                 ws_in,
  input  logic [NUM_LINES-1:0] sd_in,
  output logic                 bclk_rise,
  output logic                 ws_out,
  output logic [NUM_LINES-1:0] sd_out
);
  logic                 bclk_m, bclk_s, bclk_d;
  logic                 ws_m, ws_s;
  logic [NUM_LINES-1:0] sd_m, sd_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_m    <= 1'b0;
      bclk_s    <= 1'b0;
      bclk_d    <= 1'b0;
      ws_m      <= 1'b0;
      ws_s      <= 1'b0;
      sd_m      <= '0;
      sd_s      <= '0;
      bclk_rise <= 1'b0;
      ws_out    <= 1'b0;
      sd_out    <= '0;
    end else begin
      bclk_m    <= bclk_in;
      bclk_s    <= bclk_m;
      bclk_d    <= bclk_s;
      ws_m      <= ws_in;
      ws_s      <= ws_m;
      sd_m      <= sd_in;
      sd_s      <= sd_m;
      bclk_rise <= bclk_s & ~bclk_d;
      ws_out    <= ws_s;
      sd_out    <= sd_s;
    end
  end

  // R8: a rising edge is a single-cycle event
  a_r8_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |=> !bclk_rise);
endmodule

// File: rtl/i2s_word_capture.sv
module i2s_word_capture #(
  parameter int NUM_LINES = 4,
  parameter int SAMPLE_W  = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bclk_rise,
  input  logic                                ws,
  input  logic [NUM_LINES-1:0]                sd,
  output logic                                word_done,
  output logic                                word_right,
  output logic [NUM_LINES-1:0][SAMPLE_W-1:0]  words
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

  logic             ws_last, running, side;
  logic [CNT_W-1:0] bit_cnt;
  logic             ws_change, shift_en;

  assign ws_change = bclk_rise && (ws != ws_last);
  assign shift_en  = bclk_rise && !ws_change && running && (bit_cnt < FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_last    <= 1'b0;
      running    <= 1'b0;
      side       <= 1'b0;
      bit_cnt    <= '0;
      word_done  <= 1'b0;
      word_right <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (ws_change) begin
        ws_last <= ws;
        running <= 1'b1;
        side    <= ws;
        bit_cnt <= '0;
      end else if (shift_en) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          word_done  <= 1'b1;
          word_right <= side;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (shift_en) words[g] <= {words[g][SAMPLE_W-2:0], sd[g]};
    end
  end

  // R8: the bit counter never runs past one sample
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);
endmodule

// File: rtl/i2s_frame_packer.sv
module i2s_frame_packer
  import i2s_stream_pkg::*;
#(
  parameter int NUM_PAIRS    = 4,
  parameter int SAMPLE_W     = 24,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               word_done,
  input  logic                               word_right,
  input  logic [NUM_PAIRS-1:0][SAMPLE_W-1:0] words,
  output logic [TDATA_W-1:0]                 m_tdata,
  output logic [TID_W-1:0]                   m_tid,
  output logic                               m_tvalid,
  input  logic                               m_tready,
  output logic                               overflow
);
  localparam int NCH   = 2 * NUM_PAIRS;
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int FR_W  = $clog2(BLOCK_FRAMES);
  localparam int PAD_W = FIELD_W - SAMPLE_W;
  localparam logic [IDX_W-1:0] LAST_CH  = IDX_W'(NCH - 1);
  localparam logic [FR_W-1:0]  LAST_FR  = FR_W'(BLOCK_FRAMES - 1);
  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NCH - 1);

  logic [SAMPLE_W-1:0] left_cap [NUM_PAIRS];
  logic [SAMPLE_W-1:0] ch_buf   [NCH];
  logic                left_ok;
  logic                busy;
  logic [IDX_W-1:0]    idx;
  logic [FR_W-1:0]     frame_no;
  logic                slot_free;
  logic [3:0]          mark;
  logic [FIELD_W-1:0]  field;

  assign slot_free = !m_tvalid || m_tready;

  always_comb begin
    if (idx == '0 && frame_no == '0) mark = MARK_BLOCK;
    else if (idx[0])                 mark = MARK_RIGHT;
    else                             mark = MARK_LEFT;
    field = FIELD_W'(ch_buf[idx]) << PAD_W;
  end

  always_ff @(posedge clk) begin
    if (word_done && !word_right) begin
      for (int p = 0; p < NUM_PAIRS; p++) left_cap[p] <= words[p];
    end
    if (word_done && word_right && left_ok && !busy && !m_tvalid) begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        ch_buf[2*p]   <= left_cap[p];
        ch_buf[2*p+1] <= words[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_ok  <= 1'b0;
      busy     <= 1'b0;
      idx      <= '0;
      frame_no <= '0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tid    <= '0;
      overflow <= 1'b0;
    end else begin
      if (word_done && !word_right) left_ok <= 1'b1;
      if (word_done && word_right && left_ok) begin
        left_ok <= 1'b0;
        if (busy || m_tvalid) begin
          overflow <= 1'b1;
        end else begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end
      if (busy && slot_free) begin
        m_tvalid <= 1'b1;
        m_tdata  <= {4'b0000, field, mark};
        m_tid    <= TID_W'(idx);
        if (idx == LAST_CH) begin
          busy     <= 1'b0;
          frame_no <= (frame_no == LAST_FR) ? '0 : frame_no + 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (m_tvalid && m_tready) begin
        m_tvalid <= 1'b0;
      end
    end
  end

  // R2: a stalled word stays put
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tid));
  // R2: the next channel follows straight after an accepted one within a frame
  a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tid != LAST_TID |=>
      m_tvalid && m_tid == $past(m_tid) + 3'd1);
  // R3: odd channels carry the right marker
  a_r3_right_mark: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tid[0] |-> m_tdata[3:0] == MARK_RIGHT);
  // R3: the block marker only ever sits on channel 0
  a_r3_block_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tdata[3:0] == MARK_BLOCK |-> m_tid == '0);
  // R5: top nibble is zero
  a_r5_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tdata[31:28] == 4'b0000);
  // R9: overflow is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  if (SAMPLE_W == 16) begin : g_w16_chk
    // R7: padding bits below a 16-bit sample are zero
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> m_tdata[11:4] == 8'h00);
  end
endmodule

// File: rtl/i2s_stream_packer.sv
module i2s_stream_packer #(
  parameter int NUM_PAIRS    = 4,
  parameter int SAMPLE_W     = 24,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i2s_bclk,
  input  logic                 i2s_ws,
  input  logic [NUM_PAIRS-1:0] i2s_sd,
  output logic [31:0]          m_axis_tdata,
  output logic [2:0]           m_axis_tid,
  output logic                 m_axis_tvalid,
  input  logic                 m_axis_tready,
  output logic                 overflow
);
  logic                               bclk_rise;
  logic                               ws_s;
  logic [NUM_PAIRS-1:0]               sd_s;
  logic                               word_done, word_right;
  logic [NUM_PAIRS-1:0][SAMPLE_W-1:0] words;

  initial begin
    a_cfg_width: assert (SAMPLE_W == 16 || SAMPLE_W == 24);
    a_cfg_pairs: assert (NUM_PAIRS == 1 || NUM_PAIRS == 2 || NUM_PAIRS == 4);
  end

  i2s_edge_sync #(.NUM_LINES(NUM_PAIRS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (i2s_bclk),
    .ws_in     (i2s_ws),
    .sd_in     (i2s_sd),
    .bclk_rise (bclk_rise),
    .ws_out    (ws_s),
    .sd_out    (sd_s)
  );

  i2s_word_capture #(.NUM_LINES(NUM_PAIRS), .SAMPLE_W(SAMPLE_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_rise  (bclk_rise),
    .ws         (ws_s),
    .sd         (sd_s),
    .word_done  (word_done),
    .word_right (word_right),
    .words      (words)
  );

  i2s_frame_packer #(
    .NUM_PAIRS(NUM_PAIRS), .SAMPLE_W(SAMPLE_W), .BLOCK_FRAMES(BLOCK_FRAMES)
  ) u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_done  (word_done),
    .word_right (word_right),
    .words      (words),
    .m_tdata    (m_axis_tdata),
    .m_tid      (m_axis_tid),
    .m_tvalid   (m_axis_tvalid),
    .m_tready   (m_axis_tready),
    .overflow   (overflow)
  );

  // R1: nothing valid straight after reset
  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> !m_axis_tvalid && !overflow);
endmodule

// File: tb/i2s_stream_packer_bench.sv
module i2s_stream_packer_bench;
  localparam int NFR  = 200;
  localparam int DROP = 151;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i2s_bclk = 1'b0;
  logic        i2s_ws = 1'b0;
  logic [3:0]  i2s_sd = '0;
  logic        tready = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] tdata_a, tdata_b;
  logic [2:0]  tid_a, tid_b;
  logic        tvalid_a, tvalid_b, ovf_a, ovf_b;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int ef_a = 0, ec_a = 0, bk_a = 0, seen_a = 0;
  int ef_b = 0, ec_b = 0, bk_b = 0, seen_b = 0;

  always #10 clk = ~clk;

  i2s_stream_packer u_i2s_stream_packer (
    .clk(clk), .rst_n(rst_n), .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .m_axis_tdata(tdata_a), .m_axis_tid(tid_a), .m_axis_tvalid(tvalid_a),
    .m_axis_tready(tready), .overflow(ovf_a));

  i2s_stream_packer #(.NUM_PAIRS(1), .SAMPLE_W(16)) u_i2s_stream_packer_w16 (
    .clk(clk), .rst_n(rst_n), .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd[0]),
    .m_axis_tdata(tdata_b), .m_axis_tid(tid_b), .m_axis_tvalid(tvalid_b),
    .m_axis_tready(tready), .overflow(ovf_b));

  function automatic logic [23:0] samp(input int f, input int ch);
    logic [31:0] x;
    if (f == 3) return 24'hFFFFFF;
    if (f == 4) return 24'h000000;
    if (f == 5) return 24'h800001 ^ 24'(ch);
    x = f * 32'h9E3779B1 + ch * 32'h85EBCA77 + 32'h1234567;
    return x[27:4];
  endfunction

  function automatic logic [3:0] mark(input int ch, input int bk);
    if (ch == 0 && bk == 0) return 4'b0001;
    return (ch % 2 == 1) ? 4'b0011 : 4'b0010;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic half(input int f, input bit side);
    for (int b = 0; b < 32; b++) begin
      @(negedge clk);
      i2s_bclk = 1'b0;
      i2s_ws   = side;
      for (int p = 0; p < 4; p++) begin
        logic [23:0] s;
        s = samp(f, 2 * p + int'(side));
        i2s_sd[p] = (f >= 0 && b >= 1 && b <= 24) ? s[24 - b] : 1'b0;
      end
      repeat (4) @(negedge clk);
      i2s_bclk = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  // ready pattern with regular gaps plus a long forced stall
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tready = !stall && (cyc % 4 != 3);
    end
  end

  // 24-bit, four-pair monitor
  always @(negedge clk) begin
    if (rst_n && tvalid_a && tready) begin
      logic [31:0] exp;
      exp = {4'b0000, samp(ef_a, ec_a), mark(ec_a, bk_a)};
      check(tid_a == 3'(ec_a), "R2 R8 channel order", 32'(tid_a), 32'(ec_a));
      check(tdata_a[3:0] == exp[3:0], "R3 R4 marker", 32'(tdata_a[3:0]), 32'(exp[3:0]));
      check(tdata_a[31:28] == 4'b0000, "R5 top nibble", 32'(tdata_a[31:28]), 32'h0);
      check(tdata_a[27:4] == exp[27:4], "R6 R8 payload 24", tdata_a, exp);
      seen_a++;
      ec_a++;
      if (ec_a == 8) begin
        ec_a = 0;
        bk_a = (bk_a + 1) % 192;
        ef_a++;
        if (ef_a == DROP) ef_a++;
      end
    end
  end

  // 16-bit, one-pair monitor
  always @(negedge clk) begin
    if (rst_n && tvalid_b && tready) begin
      logic [23:0] s;
      logic [31:0] exp;
      s   = samp(ef_b, ec_b);
      exp = {4'b0000, s[23:8], 8'h00, mark(ec_b, bk_b)};
      check(tid_b == 3'(ec_b), "R2 R8 channel order w16", 32'(tid_b), 32'(ec_b));
      check(tdata_b[3:0] == exp[3:0], "R3 R4 marker w16", 32'(tdata_b[3:0]), 32'(exp[3:0]));
      check(tdata_b[11:4] == 8'h00, "R7 padding", 32'(tdata_b[11:4]), 32'h0);
      check(tdata_b[27:12] == exp[27:12], "R7 R8 payload 16", tdata_b, exp);
      seen_b++;
      ec_b++;
      if (ec_b == 2) begin
        ec_b = 0;
        bk_b = (bk_b + 1) % 192;
        ef_b++;
        if (ef_b == DROP) ef_b++;
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!tvalid_a && !ovf_a, "R1 reset held", {30'h0, tvalid_a, ovf_a}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!tvalid_a && !ovf_a && !tvalid_b, "R1 after release",
          {29'h0, tvalid_a, ovf_a, tvalid_b}, 32'h0);
    // right half without a left half before it: no output expected
    half(-1, 1'b1);
    repeat (40) @(negedge clk);
    check(seen_a == 0 && !tvalid_a, "R10 lone right half", 32'(seen_a), 32'h0);
    for (int f = 0; f < NFR; f++) begin
      if (f == 150) begin
        check(!ovf_a && !ovf_b, "R9 no overflow yet", {30'h0, ovf_a, ovf_b}, 32'h0);
        check(seen_a == 150 * 8, "R2 words before stall", 32'(seen_a), 32'(150 * 8));
        stall = 1'b1;
      end
      half(f, 1'b0);
      if (f == 152) begin
        check(tvalid_a && tid_a == 3'd0, "R2 stalled word held",
              {28'h0, tvalid_a, tid_a}, 32'h8);
        check(ovf_a && ovf_b, "R9 overflow raised", {30'h0, ovf_a, ovf_b}, 32'h3);
        stall = 1'b0;
      end
      half(f, 1'b1);
    end
    repeat (100) @(negedge clk);
    check(seen_a == (NFR - 1) * 8, "R9 R4 total words", 32'(seen_a), 32'((NFR - 1) * 8));
    check(seen_b == (NFR - 1) * 2, "R9 total words w16", 32'(seen_b), 32'((NFR - 1) * 2));
    check(ovf_a && ovf_b, "R9 overflow sticky", {30'h0, ovf_a, ovf_b}, 32'h3);
    check(!tvalid_a && !tvalid_b, "R2 idle at end", {30'h0, tvalid_a, tvalid_b}, 32'h0);
    finish_run();
  end
endmodule